// File: doc/BRIEF.md
# Interlaced Field Address Generator

This block reads a progressive frame held in memory as a series of interlaced fields. Each field start pulse launches one field. For that field the block issues one line request per kept line, and each request carries a start address and a byte length on a valid/ready handshake. The read step between lines is twice the line size, so every other stored line is passed over. A field of even parity begins at the frame base. A field of odd parity begins one line size further on. Parity alternates from one field to the next. A field-ID output tells downstream timing logic which parity is being sent, and a one-cycle done pulse marks the end of each field.

The same block provides the matching write-side line address. That side steps by one line size, so the progressive lines that arrive are packed end to end in memory. The line size and frame height are captured when a field is launched. Software can therefore reprogram them at any time, and the new values apply from the next field onward.

Top module: `ilace_field_addr_gen`

## Requirements
- R1: While and after a synchronous reset (`rst` high), `rd_valid`, `field_done` and `field_odd` are all 0. The first field launched after reset is even.
- R2: The first line request of a field has address `base_addr` when the field is even (`field_odd`=0) and `base_addr + line_bytes` when the field is odd (`field_odd`=1). Both values are sampled at launch.
- R3: Each later line request in the field has an address equal to the previous one plus 2 × the latched `line_bytes`.
- R4: With `frame_lines` = V, an even field issues (V+1)/2 line requests and an odd field issues V/2 line requests, both using integer division. After the last request, `rd_valid` is 0.
- R5: While `rd_valid` is high and `rd_ready` is low, `rd_valid`, `rd_addr` and `rd_len` stay unchanged.
- R6: `field_done` is high for exactly the one cycle that follows the clock edge which accepts the last line of a field. `rd_valid` is low in that cycle.
- R7: A `field_start` that arrives while a field is still being read is ignored. The current line sequence continues unchanged, and the parity of the next field is not affected.
- R8: `line_bytes`, `frame_lines` and `base_addr` are sampled on the edge that launches a field. `rd_len` equals the latched `line_bytes`. Changes to these inputs during a field have no effect until the next launch.
- R9: `field_odd` takes the parity of the launched field in the cycle after launch. It holds that value until the next accepted launch. Consecutive launches alternate even, odd, even, and so on.
- R10: `wr_restart` loads `wr_addr` with `base_addr` on the next edge. `wr_step` alone adds `line_bytes` to `wr_addr`. If both are high, `wr_restart` wins.
- R11: A field with zero lines issues no request. This is an odd field with V = 1, or any field with V = 0. For such a field, `field_done` pulses in the cycle after launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| base_addr | input | ADDR_W | Frame base address |
| line_bytes | input | LEN_W | Active bytes per line |
| frame_lines | input | LINES_W | Progressive frame height in lines |
| field_start | input | 1 | Launch one field (accepted only when idle) |
| rd_valid | output | 1 | Line request valid |
| rd_ready | input | 1 | Line request accepted |
| rd_addr | output | ADDR_W | Line start address |
| rd_len | output | LEN_W | Line length in bytes |
| field_odd | output | 1 | Parity of current field: 0 even, 1 odd |
| field_done | output | 1 | One-cycle pulse after the last line is accepted |
| wr_restart | input | 1 | Reload write address with base |
| wr_step | input | 1 | Advance write address by one line |
| wr_addr | output | ADDR_W | Write-side line start address |

## Verification
A parity register that is not toggling correctly shows up on the first request of the very next field. That request starts one line size away from where it should, and `field_odd` disagrees with the alternation. Both are visible the cycle after launch. A wrong line counter shows up as a `field_done` pulse one request too early or too late. A wrong step shows up at the second request of any field with a line count of at least two. The stall, busy-start and mid-field reprogramming cases each take only a few cycles to reveal a register that loads when it should hold.

// File: rtl/ilace_pkg.sv
package ilace_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ilace_state_e;
endpackage

// File: rtl/ilace_field_seq.sv
// Field sequencer: launch acceptance, parity tracking, line countdown, done pulse.
module ilace_field_seq
    import ilace_pkg::*;
#(
    parameter int LINES_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               field_start,
    input  logic [LINES_W-1:0] frame_lines,
    input  logic               rd_fire,
    output logic               launch,
    output logic               launch_odd,
    output logic               rd_valid,
    output logic               field_odd,
    output logic               field_done
);
    typedef struct packed {
        ilace_state_e       state;
        logic               next_odd;
        logic               field_odd;
        logic [LINES_W-1:0] left;
        logic               done;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [LINES_W-1:0] n_lines;

    always_comb begin
        launch     = (seq_q.state == ST_IDLE) && field_start;
        launch_odd = seq_q.next_odd;
        // even field takes the extra line when the height is odd
        n_lines    = (frame_lines >> 1) +
                     (seq_q.next_odd ? '0 : LINES_W'(frame_lines[0]));
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        if (launch) begin
            seq_d.field_odd = seq_q.next_odd;
            seq_d.next_odd  = ~seq_q.next_odd;
            if (n_lines == '0) begin
                seq_d.done = 1'b1;
            end else begin
                seq_d.state = ST_RUN;
                seq_d.left  = n_lines;
            end
        end else if (seq_q.state == ST_RUN && rd_fire) begin
            if (seq_q.left == LINES_W'(1)) begin
                seq_d.state = ST_IDLE;
                seq_d.left  = '0;
                seq_d.done  = 1'b1;
            end else begin
                seq_d.left = seq_q.left - LINES_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '{state: ST_IDLE, next_odd: 1'b0, field_odd: 1'b0,
                       left: '0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign rd_valid   = (seq_q.state == ST_RUN);
    assign field_odd  = seq_q.field_odd;
    assign field_done = seq_q.done;
endmodule

// File: rtl/ilace_rd_addr.sv
// Read-side line address: parity offset at launch, double-line step per accept.
module ilace_rd_addr #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic              launch_odd,
    input  logic              rd_fire,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [LEN_W-1:0]  line_bytes,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [LEN_W-1:0]  rd_len
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] stride;
        logic [LEN_W-1:0]  len;
    } rda_t;

    rda_t rda_d, rda_q;
    logic [ADDR_W-1:0] line_w;

    always_comb begin
        line_w = ADDR_W'(line_bytes);
        rda_d  = rda_q;
        if (launch) begin
            rda_d.addr   = base_addr + (launch_odd ? line_w : '0);
            rda_d.stride = line_w << 1;
            rda_d.len    = line_bytes;
        end else if (rd_fire) begin
            rda_d.addr = rda_q.addr + rda_q.stride;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rda_q <= '0;
        end else begin
            rda_q <= rda_d;
        end
    end

    assign rd_addr = rda_q.addr;
    assign rd_len  = rda_q.len;
endmodule

// File: rtl/ilace_wr_addr.sv
// Write-side line address: contiguous lines, step equals line size.
module ilace_wr_addr #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_restart,
    input  logic              wr_step,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [LEN_W-1:0]  line_bytes,
    output logic [ADDR_W-1:0] wr_addr
);
    logic [ADDR_W-1:0] wa_d, wa_q;

    always_comb begin
        wa_d = wa_q;
        if (wr_restart) begin
            wa_d = base_addr;
        end else if (wr_step) begin
            wa_d = wa_q + ADDR_W'(line_bytes);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wa_q <= '0;
        end else begin
            wa_q <= wa_d;
        end
    end

    assign wr_addr = wa_q;
endmodule

// File: rtl/ilace_field_addr_gen.sv
module ilace_field_addr_gen #(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 16,
    parameter int LINES_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  base_addr,
    input  logic [LEN_W-1:0]   line_bytes,
    input  logic [LINES_W-1:0] frame_lines,
    input  logic               field_start,
    output logic               rd_valid,
    input  logic               rd_ready,
    output logic [ADDR_W-1:0]  rd_addr,
    output logic [LEN_W-1:0]   rd_len,
    output logic               field_odd,
    output logic               field_done,
    input  logic               wr_restart,
    input  logic               wr_step,
    output logic [ADDR_W-1:0]  wr_addr
);
    logic launch;
    logic launch_odd;
    logic rd_fire;

    assign rd_fire = rd_valid && rd_ready;

    ilace_field_seq #(.LINES_W(LINES_W)) seq_i (
        .clk         (clk),
        .rst         (rst),
        .field_start (field_start),
        .frame_lines (frame_lines),
        .rd_fire     (rd_fire),
        .launch      (launch),
        .launch_odd  (launch_odd),
        .rd_valid    (rd_valid),
        .field_odd   (field_odd),
        .field_done  (field_done)
    );

    ilace_rd_addr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) rda_i (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .launch_odd (launch_odd),
        .rd_fire    (rd_fire),
        .base_addr  (base_addr),
        .line_bytes (line_bytes),
        .rd_addr    (rd_addr),
        .rd_len     (rd_len)
    );

    ilace_wr_addr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) wra_i (
        .clk        (clk),
        .rst        (rst),
        .wr_restart (wr_restart),
        .wr_step    (wr_step),
        .base_addr  (base_addr),
        .line_bytes (line_bytes),
        .wr_addr    (wr_addr)
    );
endmodule

// File: rtl/ilace_field_addr_chk.sv
module ilace_field_addr_chk #(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 16,
    parameter int LINES_W = 12
) (
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  base_addr,
    input logic [LEN_W-1:0]   line_bytes,
    input logic [LINES_W-1:0] frame_lines,
    input logic               field_start,
    input logic               rd_valid,
    input logic               rd_ready,
    input logic [ADDR_W-1:0]  rd_addr,
    input logic [LEN_W-1:0]   rd_len,
    input logic               field_odd,
    input logic               field_done,
    input logic               wr_restart,
    input logic               wr_step,
    input logic [ADDR_W-1:0]  wr_addr
);
    logic [ADDR_W-1:0] rd_step_w;
    logic [ADDR_W-1:0] wr_step_w;
    assign rd_step_w = ADDR_W'(rd_len) << 1;
    assign wr_step_w = ADDR_W'(line_bytes);

    // R1: outputs idle while in reset
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!rd_valid && !field_done && !field_odd));

    // R3: line-to-line step of twice the line size
    p_line_step_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_ready) |=> (!rd_valid || rd_addr == $past(rd_addr) + $past(rd_step_w)));

    // R5: request held while stalled
    p_hold_stall_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr) && $stable(rd_len)));

    // R6: done is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        field_done |=> !field_done);

    // R6: no request alongside done
    p_done_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        field_done |-> !rd_valid);

    // R7 / R9: parity cannot change while a field is in flight
    p_parity_hold_r9: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> $stable(field_odd));

    // R10: plain step advances by one line size
    p_wr_step_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_step && !wr_restart) |=> (wr_addr == $past(wr_addr) + $past(wr_step_w)));

    // R10: restart loads the base
    p_wr_restart_r10: assert property (@(posedge clk) disable iff (rst)
        wr_restart |=> (wr_addr == $past(base_addr)));

    logic unused_ok;
    assign unused_ok = ^{frame_lines, field_start};
endmodule

bind ilace_field_addr_gen ilace_field_addr_chk #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINES_W(LINES_W)
) chk_i (
    .clk(clk), .rst(rst), .base_addr(base_addr), .line_bytes(line_bytes),
    .frame_lines(frame_lines), .field_start(field_start), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_len(rd_len), .field_odd(field_odd),
    .field_done(field_done), .wr_restart(wr_restart), .wr_step(wr_step),
    .wr_addr(wr_addr)
);

// File: tb/ilace_field_addr_gen_tb_top.sv
module ilace_field_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] base_addr = '0;
    logic [15:0] line_bytes = '0;
    logic [11:0] frame_lines = '0;
    logic        field_start = 1'b0;
    logic        rd_valid;
    logic        rd_ready = 1'b0;
    logic [31:0] rd_addr;
    logic [15:0] rd_len;
    logic        field_odd;
    logic        field_done;
    logic        wr_restart = 1'b0;
    logic        wr_step = 1'b0;
    logic [31:0] wr_addr;

    always #2 clk = ~clk;  // 250 MHz

    ilace_field_addr_gen dut_i (
        .clk(clk), .rst(rst), .base_addr(base_addr), .line_bytes(line_bytes),
        .frame_lines(frame_lines), .field_start(field_start), .rd_valid(rd_valid),
        .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_len(rd_len), .field_odd(field_odd),
        .field_done(field_done), .wr_restart(wr_restart), .wr_step(wr_step),
        .wr_addr(wr_addr)
    );

    int checks = 0;
    int fails  = 0;
    bit exp_odd = 1'b0;
    bit finished = 1'b0;

    typedef struct packed {
        logic [31:0] base;
        logic [15:0] hsize;
        logic [11:0] vsize;
        logic        stall;
        logic        perturb;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{32'h0000_1000, 16'd64,   12'd8,    1'b0, 1'b0},
        '{32'h0000_1000, 16'd64,   12'd8,    1'b0, 1'b0},
        '{32'h0002_0000, 16'd48,   12'd7,    1'b1, 1'b0},
        '{32'h0002_0000, 16'd48,   12'd7,    1'b0, 1'b0},
        '{32'h0000_8000, 16'd100,  12'd5,    1'b0, 1'b1},
        '{32'h0000_8000, 16'd100,  12'd1,    1'b0, 1'b0},
        '{32'h1000_0000, 16'd1920, 12'd1080, 1'b0, 1'b0},
        '{32'h1000_0000, 16'd1920, 12'd1080, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_field(input logic [31:0] b, input logic [15:0] h,
                             input logic [11:0] v, input bit stall, input bit perturb);
        logic [31:0] ea;
        int n;
        n  = exp_odd ? int'(v) / 2 : (int'(v) + 1) / 2;
        ea = b + (exp_odd ? 32'(h) : 32'd0);
        base_addr = b; line_bytes = h; frame_lines = v;
        field_start = 1'b1; rd_ready = 1'b0;
        @(negedge clk);
        field_start = 1'b0;
        if (perturb) begin  // R8: mid-field changes must not matter
            line_bytes = h + 16'd8; frame_lines = v + 12'd4; base_addr = b + 32'h100;
        end
        chk("R9", "field_odd after launch", 32'(field_odd), 32'(exp_odd));
        if (n == 0) begin
            chk("R11", "done on empty field", 32'(field_done), 32'd1);
            chk("R11", "no request on empty field", 32'(rd_valid), 32'd0);
        end else begin
            for (int i = 0; i < n; i++) begin
                chk("R4", "valid within field", 32'(rd_valid), 32'd1);
                chk(i == 0 ? "R2" : "R3", "line address", rd_addr, ea);
                chk("R8", "line length", 32'(rd_len), 32'(h));
                chk("R6", "no early done", 32'(field_done), 32'd0);
                if (stall) begin
                    @(negedge clk);
                    chk("R5", "held valid", 32'(rd_valid), 32'd1);
                    chk("R5", "held address", rd_addr, ea);
                end
                rd_ready = 1'b1;
                @(negedge clk);
                rd_ready = 1'b0;
                ea = ea + 32'(h) * 2;
            end
            chk("R6", "done after last accept", 32'(field_done), 32'd1);
            chk("R4", "valid low after last line", 32'(rd_valid), 32'd0);
        end
        @(negedge clk);
        chk("R6", "done one cycle only", 32'(field_done), 32'd0);
        chk("R9", "parity held after field", 32'(field_odd), 32'(exp_odd));
        exp_odd = !exp_odd;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "rd_valid in reset", 32'(rd_valid), 32'd0);
        chk("R1", "field_done in reset", 32'(field_done), 32'd0);
        chk("R1", "field_odd in reset", 32'(field_odd), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "rd_valid after reset", 32'(rd_valid), 32'd0);

        // vector table
        for (int k = 0; k < 8; k++) begin
            run_field(VECS[k].base, VECS[k].hsize, VECS[k].vsize,
                      VECS[k].stall, VECS[k].perturb);
        end

        // R7: start while busy is ignored
        begin
            logic [31:0] a0;
            bit par;
            par = exp_odd;
            base_addr = 32'h4000; line_bytes = 16'd32; frame_lines = 12'd4;
            field_start = 1'b1;
            @(negedge clk);
            field_start = 1'b0;
            a0 = 32'h4000 + (par ? 32'd32 : 32'd0);
            chk("R7", "first address", rd_addr, a0);
            base_addr = 32'h9999_0000;
            field_start = 1'b1;
            @(negedge clk);
            field_start = 1'b0;
            chk("R7", "address unchanged by busy start", rd_addr, a0);
            chk("R7", "parity unchanged by busy start", 32'(field_odd), 32'(par));
            for (int i = 0; i < 2; i++) begin
                rd_ready = 1'b1;
                @(negedge clk);
                rd_ready = 1'b0;
            end
            chk("R7", "field length unchanged", 32'(field_done), 32'd1);
            exp_odd = !exp_odd;
            @(negedge clk);
            run_field(32'h5000, 16'd16, 12'd4, 1'b0, 1'b0);  // R7: next parity toggled once
        end

        // R1: reset during a field returns to even
        base_addr = 32'h6000; line_bytes = 16'd8; frame_lines = 12'd6;
        field_start = 1'b1;
        @(negedge clk);
        field_start = 1'b0;
        rd_ready = 1'b1;
        @(negedge clk);
        rd_ready = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        chk("R1", "valid cleared by reset", 32'(rd_valid), 32'd0);
        chk("R1", "parity cleared by reset", 32'(field_odd), 32'd0);
        rst = 1'b0;
        exp_odd = 1'b0;
        run_field(32'h7000, 16'd8, 12'd3, 1'b0, 1'b0);
        run_field(32'h7000, 16'd8, 12'd0, 1'b0, 1'b0);  // R11: zero height

        // R10: write-side addressing
        base_addr = 32'h0300_0000; line_bytes = 16'd720;
        wr_restart = 1'b1;
        @(negedge clk);
        wr_restart = 1'b0;
        chk("R10", "restart loads base", wr_addr, 32'h0300_0000);
        wr_step = 1'b1;
        for (int i = 1; i <= 3; i++) begin
            @(negedge clk);
            chk("R10", "step by line size", wr_addr, 32'h0300_0000 + 32'(i) * 32'd720);
        end
        wr_restart = 1'b1;
        @(negedge clk);
        wr_restart = 1'b0; wr_step = 1'b0;
        chk("R10", "restart beats step", wr_addr, 32'h0300_0000);
        @(negedge clk);
        chk("R10", "idle hold", wr_addr, 32'h0300_0000);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule